// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM Without Bus Turnaround

A synchronous static RAM model with an 18-bit word made of two 9-bit byte lanes and a parameterized address width. The full-size part uses a 19-bit address (524,288 words). The default is a 6-bit address so the model stays small in simulation. A command is accepted on a rising clock edge when the advance strobe is high, every chip select is active and snooze is low. The address, the read/write select and the byte-lane enables are registered on that edge.

Read data flows through. It is driven in the same cycle the read is launched, taken combinationally from the array at the registered address. Write data is taken from the data bus on the next rising edge. Either way, the bus cycle that follows a command edge belongs to that command. Reads and writes can therefore alternate on every edge with no idle bus cycle.

The output enable and the snooze input act on the output drivers directly, with no clock. Snooze also blocks commands and array updates at any edge where it is high. The bidirectional bus is split into an input, an output and a drive-enable port.

Top module: `flowthru_sram`

## Requirements
- R1: A read is accepted on a rising edge with adv_i=1, cs0_n_i=0, cs1_i=1, cs2_n_i=0, we_n_i=1 and snooze_i=0. In the cycle after that edge, dq_oe_o=1 (while oe_n_i=0) and dq_o holds the word stored at the captured address.
- R2: A write is accepted on an edge under the same conditions but with we_n_i=0. The address and lane enables are captured on that edge. The data word is taken from dq_i on the following rising edge. During the data cycle, dq_oe_o=0.
- R3: bw_n_i[0]=0 enables data bits 8:0 and bw_n_i[1]=0 enables bits 17:9. A lane whose enable is high keeps its old contents.
- R4: Reads and writes may be issued on consecutive edges with no idle cycle. A read issued on the edge that completes a write to the same address returns the newly written value.
- R5: oe_n_i=1 forces dq_oe_o=0 at once, without waiting for a clock edge. Returning oe_n_i to 0 restores the drive in the same cycle.
- R6: If any chip select is inactive (cs0_n_i=1, cs1_i=0 or cs2_n_i=1) at an edge with adv_i=1, the cycle is a deselect. No write is scheduled, and dq_oe_o=0 in the following cycle.
- R7: An edge with adv_i=0 starts no access, and dq_oe_o=0 in the following cycle.
- R8: While snooze_i=1, dq_oe_o=0 at once. At an edge where snooze_i=1, no command is accepted and no array write happens, including the data phase of an earlier write. Stored contents are retained.
- R9: While rst_ni=0 and right after it is released, no access is pending and dq_oe_o=0.
- R10: Whenever dq_oe_o=0, dq_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset of the command register |
| adv_i | input | 1 | Advance/load strobe; high launches a new access |
| cs0_n_i | input | 1 | Chip select, active low |
| cs1_i | input | 1 | Chip select, active high |
| cs2_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Read/write select: 1 read, 0 write |
| bw_n_i | input | 2 | Byte-lane write enables, active low; bit 0 for bits 8:0, bit 1 for bits 17:9 |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| snooze_i | input | 1 | Unclocked power-down request, active high |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | 18 | Data bus, inbound half |
| dq_o | output | 18 | Data bus, outbound half |
| dq_oe_o | output | 1 | Drive enable for the data bus |

## Verification
Read data and the drive enable are due in the cycle right after the command edge. The bench therefore samples them 2 ns after that rising edge, well before the next edge. Write data is driven during that same cycle and lands on the next edge. Each write is then checked with a read issued on that completing edge, whose result is sampled 2 ns later. The output-enable and snooze effects need no clock, so they are checked a few nanoseconds after the input toggles inside a single cycle, and again after it is restored.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/sram_cmd_reg.sv
module sram_cmd_reg
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              adv_i,
    input  logic              sel_ok_i,
    input  logic              we_n_i,
    input  logic [LANES-1:0]  bw_n_i,
    input  logic              snooze_i,
    input  logic [ADDR_W-1:0] addr_i,
    output op_e               op_o,
    output logic [LANES-1:0]  lane_we_o,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        op_e               op;
        logic [LANES-1:0]  lane_we;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d      = cmd_q;
        cmd_d.op   = OP_IDLE;
        if (adv_i && sel_ok_i && !snooze_i) begin
            cmd_d.op      = we_n_i ? OP_READ : OP_WRITE;
            cmd_d.lane_we = ~bw_n_i;
            cmd_d.addr    = addr_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmd_q <= '{op: OP_IDLE, lane_we: '0, addr: '0};
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign op_o      = cmd_q.op;
    assign lane_we_o = cmd_q.lane_we;
    assign addr_o    = cmd_q.addr;

    // R2: an accepted command holds the address seen at its edge
    a_r2_addr_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && sel_ok_i && !snooze_i) |=> (addr_o == $past(addr_i)) && (op_o != OP_IDLE));

    // R8: snooze at an edge blocks the command
    a_r8_snooze_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snooze_i |=> (op_o == OP_IDLE));

endmodule

// File: rtl/sram_array.sv
module sram_array
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              wr_en_i,
    input  logic [LANES-1:0]  lane_we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk_i) begin
            if (wr_en_i && lane_we_i[g]) begin
                cells[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = cells[addr_i];

        // R3: a disabled lane keeps its word across a write edge
        a_r3_lane_hold: assert property (@(posedge clk_i)
            (wr_en_i && !lane_we_i[g]) |=> ($past(addr_i) != addr_i)
                || (rdata_o[g*LANE_W +: LANE_W] == $past(rdata_o[g*LANE_W +: LANE_W])));
    end

endmodule

// File: rtl/sram_out_gate.sv
module sram_out_gate
    import sram_pkg::*;
(
    input  op_e               op_i,
    input  logic              oe_n_i,
    input  logic              snooze_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic [WORD_W-1:0] dq_o,
    output logic              dq_oe_o
);

    logic drive;

    always_comb begin
        drive   = (op_i == OP_READ) && !oe_n_i && !snooze_i;
        dq_oe_o = drive;
        dq_o    = drive ? rdata_i : '0;
    end

endmodule

// File: rtl/flowthru_sram.sv
module flowthru_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              adv_i,
    input  logic              cs0_n_i,
    input  logic              cs1_i,
    input  logic              cs2_n_i,
    input  logic              we_n_i,
    input  logic [1:0]        bw_n_i,
    input  logic              oe_n_i,
    input  logic              snooze_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [17:0]       dq_i,
    output logic [17:0]       dq_o,
    output logic              dq_oe_o
);

    logic              sel_ok;
    op_e               op_q;
    logic [LANES-1:0]  lane_we_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_fire;
    logic [WORD_W-1:0] rdata;

    assign sel_ok  = !cs0_n_i && cs1_i && !cs2_n_i;
    assign wr_fire = (op_q == OP_WRITE) && !snooze_i;

    sram_cmd_reg #(.ADDR_W(ADDR_W)) u_cmd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .adv_i    (adv_i),
        .sel_ok_i (sel_ok),
        .we_n_i   (we_n_i),
        .bw_n_i   (bw_n_i),
        .snooze_i (snooze_i),
        .addr_i   (addr_i),
        .op_o     (op_q),
        .lane_we_o(lane_we_q),
        .addr_o   (addr_q)
    );

    sram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk_i    (clk_i),
        .wr_en_i  (wr_fire),
        .lane_we_i(lane_we_q),
        .addr_i   (addr_q),
        .wdata_i  (dq_i),
        .rdata_o  (rdata)
    );

    sram_out_gate u_gate (
        .op_i     (op_q),
        .oe_n_i   (oe_n_i),
        .snooze_i (snooze_i),
        .rdata_i  (rdata),
        .dq_o     (dq_o),
        .dq_oe_o  (dq_oe_o)
    );

    // R1: an accepted read drives the bus in the next cycle
    a_r1_read_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && sel_ok && we_n_i && !snooze_i) |=> (oe_n_i || snooze_i || dq_oe_o));

    // R2: the data cycle of a write leaves the bus undriven
    a_r2_write_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && sel_ok && !we_n_i && !snooze_i) |=> !dq_oe_o);

    // R6: deselect leaves the bus undriven next cycle
    a_r6_deselect_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !sel_ok) |=> !dq_oe_o);

    // R7: no advance, no drive next cycle
    a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> !dq_oe_o);

    // R5: output enable overrides the clocked state
    a_r5_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oe_n_i |-> !dq_oe_o);

    // R8: snooze holds the drivers off
    a_r8_snooze_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snooze_i |-> !dq_oe_o);

    // R10: the undriven bus reads as zero
    a_r10_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dq_oe_o |-> (dq_o == '0));

endmodule

// File: tb/flowthru_sram_bench.sv
module flowthru_sram_bench;

    localparam int AW = 6;
    localparam int VW = 48;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adv = 1'b0, cs0_n = 1'b0, cs1 = 1'b1, cs2_n = 1'b0;
    logic          we_n = 1'b1, oe_n = 1'b0, snooze = 1'b0;
    logic [1:0]    bw_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [17:0]   din = '0;
    logic [17:0]   dout;
    logic          doe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    flowthru_sram #(.ADDR_W(AW)) u_flowthru_sram (
        .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .cs0_n_i(cs0_n), .cs1_i(cs1),
        .cs2_n_i(cs2_n), .we_n_i(we_n), .bw_n_i(bw_n), .oe_n_i(oe_n),
        .snooze_i(snooze), .addr_i(addr), .dq_i(din), .dq_o(dout), .dq_oe_o(doe)
    );

    // row: adv, sel_ok, we_n, bw_n[1:0], addr[5:0], din[17:0], exp_oe, exp_dq[17:0]
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 2'b00, 6'd1, 18'h00000, 1'b0, 18'h00000}, // R2 write a1
        {1'b1, 1'b1, 1'b0, 2'b00, 6'd2, 18'h12345, 1'b0, 18'h00000}, // R4 write a2, data a1
        {1'b1, 1'b1, 1'b1, 2'b11, 6'd1, 18'h2ABCD, 1'b1, 18'h12345}, // R1 read a1
        {1'b1, 1'b1, 1'b0, 2'b10, 6'd1, 18'h00000, 1'b0, 18'h00000}, // R3 low lane only
        {1'b1, 1'b1, 1'b1, 2'b11, 6'd1, 18'h3FF55, 1'b1, 18'h12355}, // R3/R4 read-after-write
        {1'b1, 1'b1, 1'b1, 2'b11, 6'd2, 18'h00000, 1'b1, 18'h2ABCD}, // R1 read a2
        {1'b0, 1'b1, 1'b1, 2'b11, 6'd2, 18'h00000, 1'b0, 18'h00000}, // R7 no advance
        {1'b1, 1'b0, 1'b0, 2'b00, 6'd2, 18'h00000, 1'b0, 18'h00000}, // R6 deselected write
        {1'b1, 1'b1, 1'b1, 2'b11, 6'd2, 18'h00001, 1'b1, 18'h2ABCD}, // R6 contents kept
        {1'b1, 1'b1, 1'b0, 2'b01, 6'd2, 18'h00000, 1'b0, 18'h00000}, // R3 high lane only
        {1'b1, 1'b1, 1'b1, 2'b11, 6'd2, 18'h00000, 1'b1, 18'h001CD}  // R3 high cleared
    };

    task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got oe/dq=%h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic c0n, input logic c1, input logic c2n,
                        input logic wn, input logic [1:0] bn, input logic [AW-1:0] ad,
                        input logic [17:0] d, input logic sz);
        @(negedge clk);
        adv = a; cs0_n = c0n; cs1 = c1; cs2_n = c2n; we_n = wn;
        bw_n = bn; addr = ad; din = d; snooze = sz;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R9 in reset", {doe, dout}, 19'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R9 after release", {doe, dout}, 19'h0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            step(v[47], ~v[46], v[46], 1'b0, v[45], v[44:43], v[42:37], v[36:19], 1'b0);
            check($sformatf("R1/R2/R3/R4/R6/R7/R10 row %0d", i), {doe, dout}, v[18:0]);
        end

        // R5: asynchronous output enable during a read cycle of a2
        step(1, 0, 1, 0, 1, 2'b11, 6'd2, 18'h0, 0);
        #1 oe_n = 1'b1;
        #1 check("R5 oe high", {doe, dout}, 19'h0);
        #1 oe_n = 1'b0;
        #1 check("R5 oe restored", {doe, dout}, {1'b1, 18'h001CD});

        // R6: the other two selects each deselect a write
        step(1, 0, 0, 0, 0, 2'b00, 6'd2, 18'h0, 0);
        step(1, 0, 1, 1, 0, 2'b00, 6'd2, 18'h3FFFF, 0);
        check("R6 cs2 deselect quiet", {doe, dout}, 19'h0);
        step(1, 0, 1, 0, 1, 2'b11, 6'd2, 18'h3FFFF, 0);
        check("R6 cs1/cs2 no write", {doe, dout}, {1'b1, 18'h001CD});

        // R8: snooze mid-cycle, command blocked, data phase dropped
        #1 snooze = 1'b1;
        #1 check("R8 snooze drops drive", {doe, dout}, 19'h0);
        #1 snooze = 1'b0;
        step(1, 0, 1, 0, 0, 2'b00, 6'd5, 18'h0, 0);
        step(0, 0, 1, 0, 1, 2'b11, 6'd0, 18'h0AAAA, 0);
        step(1, 0, 1, 0, 0, 2'b00, 6'd5, 18'h0, 0);
        step(1, 0, 1, 0, 1, 2'b11, 6'd5, 18'h15555, 1);
        check("R8 read ignored under snooze", {doe, dout}, 19'h0);
        step(1, 0, 1, 0, 1, 2'b11, 6'd5, 18'h0, 0);
        check("R8 contents retained", {doe, dout}, {1'b1, 18'h0AAAA});

        // R4: alternating write/read every edge on a fresh address
        step(1, 0, 1, 0, 0, 2'b00, 6'd9, 18'h0, 0);
        step(1, 0, 1, 0, 1, 2'b11, 6'd9, 18'h2F0F0, 0);
        check("R4 back-to-back", {doe, dout}, {1'b1, 18'h2F0F0});

        finish_run();
    end

endmodule